// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block holds the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against: an empty-side offset and a full-side offset, each as wide as the FIFO pointer. Software or board logic can change both values through a one-bit serial input. The bits are clocked in on the write clock while a serial enable is high. One continuous chain fills the empty-side offset first, lowest bit first, and then the full-side offset, again lowest bit first. The chain is twice the pointer width long.

At master reset both offsets take a default value. The level of a load-select input during reset chooses between two defaults: 127 when it is low, and 1023 when it is high. A bit position counter tracks where the chain stands. It survives pauses in the serial enable, pulses a completion strobe after the last bit, and then starts the chain again at the empty-side LSB.

Memory writes and serial loading share the write clock. The block forwards a memory write strobe only in cycles where serial loading is not active.

Top module: `flagOfsLoader`

## Requirements
- R1: On each rising clock edge with `serEn` high, exactly one bit is taken from `serIn` into the offset bit the chain position selects. With `serEn` low, neither offset changes.
- R2: Chain positions 0 to PTR_W-1 write `emptyOfs` bits 0 to PTR_W-1 in ascending order. Positions PTR_W to 2*PTR_W-1 then write `fullOfs` bits 0 to PTR_W-1 in ascending order.
- R3: The chain is 2*PTR_W bits long. In the cycle after the edge that captures position 2*PTR_W-1, `loadDone` is high for exactly one cycle. At all other times it is low.
- R4: After position 2*PTR_W-1 is captured, the next captured bit goes to `emptyOfs` bit 0.
- R5: A master reset (`mrstN` low at a rising edge) with `loadSel` low sets both offsets to 127 (low byte 0x7F, upper bits 0), sets the chain position to 0 and clears `loadDone`.
- R6: A master reset with `loadSel` high sets both offsets to 1023 (low byte 0xFF, bits 9:8 equal to 2'b11, higher bits 0).
- R7: `memWrite` equals `wrEn` when `serEn` is low, and is 0 whenever `serEn` is high.
- R8: Cycles with `serEn` low do not move the chain position. A load split by idle gaps yields the same offsets as an uninterrupted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| mrstN | input | 1 | Master reset, active low, sampled on the rising edge |
| loadSel | input | 1 | Selects the default offsets at master reset |
| serEn | input | 1 | Serial load enable |
| wrEn | input | 1 | Memory write request |
| serIn | input | 1 | Serial offset data |
| emptyOfs | output | PTR_W | Empty-side offset |
| fullOfs | output | PTR_W | Full-side offset |
| memWrite | output | 1 | Memory write strobe, blocked during serial loading |
| loadDone | output | 1 | One-cycle pulse after the last chain bit |

## Verification
The hardest situations to reach are the wrap from the last full-offset bit back to the empty-offset LSB, and a load broken up by idle gaps. In both, a position error shows up only in the values captured afterwards.

The stimulus completes a whole chain, lets `loadDone` fire, and then sends a few more bits. These must land in `emptyOfs` and leave `fullOfs` alone. A second load is interleaved with idle cycles in which `wrEn` toggles, so every captured bit's destination is compared on every clock against a position-tracking model.

// File: rtl/flagOfsPkg.sv
package flagOfsPkg;

  // Strobes from the control to the datapath for one clock.
  typedef struct packed {
    logic capEmpty;  // capture serIn into the empty-side offset
    logic capFull;   // capture serIn into the full-side offset
    logic lastBit;   // this capture ends the chain
  } ofsStrobe_t;

endpackage

// File: rtl/flagOfsCtl.sv
module flagOfsCtl
  import flagOfsPkg::*;
#(
  parameter int PTR_W = 19
) (
  input  logic                     clk,
  input  logic                     mrstN,
  input  logic                     serEn,
  input  logic                     wrEn,
  output ofsStrobe_t               strobe,
  output logic [$clog2(PTR_W)-1:0] segPos,
  output logic                     memWrite,
  output logic                     loadDone
);
  localparam int CHAIN = 2 * PTR_W;
  localparam int CNT_W = $clog2(CHAIN);
  localparam int SEG_W = $clog2(PTR_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CHAIN - 1);
  localparam logic [CNT_W-1:0] SEG_BASE = CNT_W'(PTR_W);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] segWide;
  logic             inFull;

  assign inFull  = (bitCnt >= SEG_BASE);
  assign segWide = inFull ? (bitCnt - SEG_BASE) : bitCnt;
  assign segPos  = segWide[SEG_W-1:0];

  always_comb begin
    strobe.capEmpty = serEn && !inFull;
    strobe.capFull  = serEn && inFull;
    strobe.lastBit  = serEn && (bitCnt == LAST_POS);
  end

  // Serial loading takes the write clock; memory writes yield to it.
  assign memWrite = wrEn && !serEn;

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      bitCnt   <= '0;
      loadDone <= 1'b0;
    end else begin
      loadDone <= strobe.lastBit;
      if (serEn) begin
        if (strobe.lastBit) bitCnt <= '0;
        else                bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/flagOfsDatapath.sv
module flagOfsDatapath
  import flagOfsPkg::*;
#(
  parameter int PTR_W = 19
) (
  input  logic                     clk,
  input  logic                     mrstN,
  input  logic                     loadSel,
  input  logic                     serIn,
  input  ofsStrobe_t               strobe,
  input  logic [$clog2(PTR_W)-1:0] segPos,
  output logic [PTR_W-1:0]         emptyOfs,
  output logic [PTR_W-1:0]         fullOfs
);
  localparam int SEG_W = $clog2(PTR_W);
  localparam int HI_W  = PTR_W - 10;

  logic [PTR_W-1:0] dflVal;
  logic [PTR_W-1:0] emptyNxt;
  logic [PTR_W-1:0] fullNxt;

  // Default: 127 with loadSel low, 1023 with loadSel high.
  assign dflVal = {{HI_W{1'b0}}, {2{loadSel}}, loadSel, 7'h7F};

  for (genvar i = 0; i < PTR_W; i++) begin : g_bit
    logic hit;
    assign hit         = (segPos == SEG_W'(i));
    assign emptyNxt[i] = (strobe.capEmpty && hit) ? serIn : emptyOfs[i];
    assign fullNxt[i]  = (strobe.capFull && hit) ? serIn : fullOfs[i];
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      emptyOfs <= dflVal;
      fullOfs  <= dflVal;
    end else begin
      emptyOfs <= emptyNxt;
      fullOfs  <= fullNxt;
    end
  end

endmodule

// File: rtl/flagOfsLoader.sv
module flagOfsLoader
  import flagOfsPkg::*;
#(
  parameter int PTR_W = 19
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             loadSel,
  input  logic             serEn,
  input  logic             wrEn,
  input  logic             serIn,
  output logic [PTR_W-1:0] emptyOfs,
  output logic [PTR_W-1:0] fullOfs,
  output logic             memWrite,
  output logic             loadDone
);
  localparam int SEG_W = $clog2(PTR_W);

  ofsStrobe_t       strobe;
  logic [SEG_W-1:0] segPos;

  flagOfsCtl #(.PTR_W(PTR_W)) u_ctl (
    .clk      (clk),
    .mrstN    (mrstN),
    .serEn    (serEn),
    .wrEn     (wrEn),
    .strobe   (strobe),
    .segPos   (segPos),
    .memWrite (memWrite),
    .loadDone (loadDone)
  );

  flagOfsDatapath #(.PTR_W(PTR_W)) u_dp (
    .clk      (clk),
    .mrstN    (mrstN),
    .loadSel  (loadSel),
    .serIn    (serIn),
    .strobe   (strobe),
    .segPos   (segPos),
    .emptyOfs (emptyOfs),
    .fullOfs  (fullOfs)
  );

endmodule

// File: rtl/flagOfsChecker.sv
module flagOfsChecker #(
  parameter int PTR_W = 19
) (
  input logic             clk,
  input logic             mrstN,
  input logic             serEn,
  input logic             wrEn,
  input logic [PTR_W-1:0] emptyOfs,
  input logic [PTR_W-1:0] fullOfs,
  input logic             memWrite,
  input logic             loadDone,
  input logic             capEmpty,
  input logic             capFull
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!mrstN)
    !serEn |=> ($stable(emptyOfs) && $stable(fullOfs)));            // R1

  AST_EMPTY_PHASE: assert property (@(posedge clk) disable iff (!mrstN)
    capEmpty |=> $stable(fullOfs));                                 // R2

  AST_FULL_PHASE: assert property (@(posedge clk) disable iff (!mrstN)
    capFull |=> $stable(emptyOfs));                                 // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!mrstN)
    loadDone |=> !loadDone);                                        // R3

  AST_DONE_FROM_LOAD: assert property (@(posedge clk) disable iff (!mrstN)
    loadDone |-> $past(serEn));                                     // R3

  AST_NO_MEM_ON_SERIAL: assert property (@(posedge clk) disable iff (!mrstN)
    serEn |-> !memWrite);                                           // R7

  AST_MEM_PASS: assert property (@(posedge clk) disable iff (!mrstN)
    (!serEn && wrEn) |-> memWrite);                                 // R7

endmodule

bind flagOfsLoader flagOfsChecker #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .mrstN    (mrstN),
  .serEn    (serEn),
  .wrEn     (wrEn),
  .emptyOfs (emptyOfs),
  .fullOfs  (fullOfs),
  .memWrite (memWrite),
  .loadDone (loadDone),
  .capEmpty (strobe.capEmpty),
  .capFull  (strobe.capFull)
);

// File: tb/flagOfsLoader_tb.sv
module flagOfsLoader_tb;
  localparam int PW = 19;
  localparam int CH = 2 * PW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic mrstN = 1'b0, loadSel = 1'b0, serEn = 1'b0, wrEn = 1'b0, serIn = 1'b0;
  logic [PW-1:0] emptyOfs, fullOfs;
  logic memWrite, loadDone;

  flagOfsLoader #(.PTR_W(PW)) u_dut (
    .clk(clk), .mrstN(mrstN), .loadSel(loadSel), .serEn(serEn), .wrEn(wrEn),
    .serIn(serIn), .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .memWrite(memWrite), .loadDone(loadDone)
  );

  int nChk = 0;
  int nFail = 0;
  // Reference model: position in the chain and expected outputs.
  int pos = 0;
  logic [PW-1:0] mE, mF;
  logic mDone;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic doReset(logic sel, string tag);
    @(negedge clk);
    mrstN = 1'b0; loadSel = sel; serEn = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    mrstN = 1'b1;
    mE = sel ? PW'(1023) : PW'(127);
    mF = mE; pos = 0; mDone = 1'b0;
    chk(tag, "emptyOfs default", 64'(emptyOfs), 64'(mE));
    chk(tag, "fullOfs default", 64'(fullOfs), 64'(mF));
    chk(tag, "loadDone after reset", 64'(loadDone), 64'(0));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(logic se, logic we, logic si, string tag);
    serEn = se; wrEn = we; serIn = si;
    #1;
    chk("R7", "memWrite", 64'(memWrite), 64'(we & ~se));
    if (se) begin
      if (pos < PW) mE[pos] = si;
      else          mF[pos-PW] = si;
      mDone = (pos == CH-1);
      pos = (pos + 1) % CH;
    end else begin
      mDone = 1'b0;
    end
    @(negedge clk);
    chk(tag, "emptyOfs", 64'(emptyOfs), 64'(mE));
    chk(tag, "fullOfs", 64'(fullOfs), 64'(mF));
    chk("R3", "loadDone", 64'(loadDone), 64'(mDone));
  endtask

  task automatic loadChain(logic [CH-1:0] pat, logic we, string tag);
    for (int i = 0; i < CH; i++) step(1'b1, we, pat[i], tag);
  endtask

  initial begin
    logic [CH-1:0] patA, patB, patC;
    patA = {19'h2C3E1, 19'h5A5A5};
    patB = {19'h7_0F0F, 19'h1_2345};
    patC = {19'h0_0001, 19'h4_0000};

    doReset(1'b0, "R5");
    // Full chain with wrEn held high: memory writes blocked (R7), order checked (R2).
    loadChain(patA, 1'b1, "R2");
    // Idle: no change with serEn low, writes pass through (R1).
    for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b1, "R1");
    // Load split by idle gaps (R8).
    for (int i = 0; i < CH; i++) begin
      step(1'b1, 1'b0, patB[i], "R8");
      if (i % 3 == 2) begin
        step(1'b0, 1'b1, ~patB[i], "R8");
        step(1'b0, 1'b0, 1'b1, "R8");
      end
    end
    // After the wrap, bits land in the empty-side LSBs again (R4).
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, i[0], "R4");
    chk("R4", "emptyOfs low bits after wrap", 64'(emptyOfs[4:0]), 64'(5'b01010));

    doReset(1'b1, "R6");
    loadChain(patC, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule